// File: doc/BRIEF.md
# Nibble Hamming Lane-Striping Codec

This block protects bytes that are spread bit by bit across seven storage lanes. On the write side it takes a byte and cuts it into two 4-bit halves. It turns each half into a seven-bit single-error-correcting codeword and puts that codeword on a seven-bit lane bus, one bit per lane. A byte therefore needs two lane transfers and carries six check bits in total.

On the read side it takes seven-bit lane words, computes a three-bit syndrome for each one and repairs any single wrong bit. It then joins the two recovered halves back into a byte. Because every bit of a codeword sits in a different lane, a single dead or noisy lane corrupts at most one bit per codeword, and the decoder can always recover that bit.

Both directions use valid/ready handshakes. A stall on either side holds the byte in flight without losing it. Each half-byte costs one clock, so with no backpressure the block moves one byte every two cycles in each direction.

Top module: `nibble_stripe_codec`

## Requirements
- R1: After reset, `tx_lane_valid` and `rd_valid` are 0 and both `wr_ready` and `rx_lane_ready` are 1.
- R2: Lane bit i carries codeword position i+1. Check bits sit on lanes 0, 1 and 3. Data bits d0..d3 of a nibble sit on lanes 2, 4, 5 and 6. Parity is even: lane0 = d0^d1^d3, lane1 = d0^d2^d3, lane3 = d1^d2^d3.
- R3: One cycle after a byte is accepted on the write port, `tx_lane_valid` is 1 and the lane bus carries the codeword of bits [3:0]. The codeword of bits [7:4] follows on the next lane transfer.
- R4: While `tx_lane_ready` is held at 1, `wr_ready` is 1 in the cycle that the second codeword is on the lanes. The next byte is then accepted without a gap, so the block keeps two lane cycles per byte.
- R5: While `tx_lane_valid` is 1 and `tx_lane_ready` is 0, `tx_lane_bits` does not change and `wr_ready` is 0.
- R6: A received codeword with at most one flipped bit, on any of the seven lanes, decodes to the nibble that was encoded.
- R7: `rd_fix[0]` is 1 exactly when the first codeword of the byte had a nonzero syndrome, and `rd_fix[1]` is the same flag for the second codeword.
- R8: The first lane word accepted for a byte supplies `rd_data[3:0]` and the second supplies `rd_data[7:0]`'s upper half. `rd_valid` rises one cycle after the second word is accepted.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` and `rd_fix` hold their values. A pending second codeword is not taken (`rx_lane_ready` is 0) until the byte is read. It is taken in the same cycle the byte leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Byte to encode |
| tx_lane_valid | output | 1 | Codeword present on the outgoing lanes |
| tx_lane_ready | input | 1 | Outgoing lanes take the codeword |
| tx_lane_bits | output | 7 | Outgoing codeword, one bit per lane |
| rx_lane_valid | input | 1 | Incoming codeword present |
| rx_lane_ready | output | 1 | Incoming codeword taken this cycle |
| rx_lane_bits | input | 7 | Incoming codeword, one bit per lane |
| rd_valid | output | 1 | Decoded byte present |
| rd_ready | input | 1 | Consumer takes the decoded byte |
| rd_data | output | 8 | Decoded byte |
| rd_fix | output | 2 | Per-nibble corrected flags for `rd_data` |

## Verification
Two read-side events can land on the same edge: the consumer pops a finished byte while the decoder completes the next byte from its second codeword. The bench stalls `rd_ready` with one byte waiting and offers the second codeword of a new byte, then checks that `rx_lane_ready` stays low and that the old byte holds. It then releases `rd_ready` and checks that the new byte and its flags appear in the next cycle. On the write side it also checks the edge where the last codeword leaves and a new byte is accepted together.

// File: rtl/nhs_pkg.sv
package nhs_pkg;

    localparam int NIB_W = 4;
    localparam int CHK_W = 3;
    localparam int CW_W  = NIB_W + CHK_W;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CW_W-1:0]  cw_t;
    typedef logic [CHK_W-1:0] syn_t;

    // position p (1-based) is a check position when p is a power of two
    function automatic logic nhs_is_check(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic cw_t nhs_encode(input nib_t d);
        cw_t  cw;
        int   j;
        logic par;
        cw = '0;
        j  = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!nhs_is_check(p)) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1) par = par ^ cw[p-1];
            end
            cw[(1 << k) - 1] = par;
        end
        return cw;
    endfunction

    function automatic syn_t nhs_syndrome(input cw_t cw);
        syn_t s;
        s = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1) s[k] = s[k] ^ cw[p-1];
            end
        end
        return s;
    endfunction

    function automatic nib_t nhs_extract(input cw_t cw);
        nib_t d;
        int   j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!nhs_is_check(p)) begin
                d[j] = cw[p-1];
                j++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/nhs_ham_enc.sv
module nhs_ham_enc
    import nhs_pkg::*;
(
    input  nib_t nib_i,
    output cw_t  cw_o
);

    always_comb begin
        cw_o = nhs_encode(nib_i);
    end

    always_comb begin
        if (!$isunknown(nib_i)) begin
            AST_ENC_ZERO_SYNDROME: assert (nhs_syndrome(cw_o) == '0) else $error("encoded word fails parity"); // R2
            AST_ENC_DATA_RECOVER: assert (nhs_extract(cw_o) == nib_i) else $error("data bits misplaced"); // R2
        end
    end

endmodule

// File: rtl/nhs_ham_dec.sv
module nhs_ham_dec
    import nhs_pkg::*;
(
    input  cw_t  cw_i,
    output nib_t nib_o,
    output logic err_o
);

    syn_t syn;
    cw_t  fixed;

    always_comb begin
        syn   = nhs_syndrome(cw_i);
        fixed = cw_i;
        if (syn != '0) begin
            fixed[int'(syn) - 1] = ~cw_i[int'(syn) - 1];
        end
        err_o = (syn != '0);
        nib_o = nhs_extract(fixed);
    end

    always_comb begin
        if (!$isunknown(cw_i)) begin
            AST_DEC_REPAIRED_CLEAN: assert (nhs_syndrome(fixed) == '0) else $error("repair left bad syndrome"); // R6
        end
    end

endmodule

// File: rtl/nhs_stripe_tx.sv
module nhs_stripe_tx
    import nhs_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              lane_valid_o,
    input  logic              lane_ready_i,
    output cw_t               lane_bits_o
);

    localparam int NIBBLES = DATA_W / NIB_W;
    localparam int PH_W    = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NIBBLES - 1);

    typedef struct packed {
        logic              busy;
        logic [PH_W-1:0]   phase;
        logic [DATA_W-1:0] data;
    } tx_state_t;

    tx_state_t st_d, st_q;
    nib_t      cur_nib;
    logic      on_last;

    nhs_ham_enc u_enc (
        .nib_i (cur_nib),
        .cw_o  (lane_bits_o)
    );

    always_comb begin
        st_d         = st_q;
        cur_nib      = st_q.data[st_q.phase*NIB_W +: NIB_W];
        on_last      = (st_q.phase == LAST_PH);
        lane_valid_o = st_q.busy;
        wr_ready_o   = !st_q.busy || (on_last && lane_ready_i);

        if (st_q.busy && lane_ready_i) begin
            if (on_last) begin
                st_d.busy  = 1'b0;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end

        if (wr_valid_i && wr_ready_o) begin
            st_d.busy  = 1'b1;
            st_d.phase = '0;
            st_d.data  = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid_o && !lane_ready_i) |=> (lane_valid_o && $stable(lane_bits_o))) else $error("lane word moved in stall"); // R5

    AST_NO_BYTE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid_o && !lane_ready_i) |-> !wr_ready_o) else $error("byte taken during stall"); // R5

    AST_FIRST_WORD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_ready_o) |=> lane_valid_o) else $error("no codeword after accept"); // R3

endmodule

// File: rtl/nhs_stripe_rx.sv
module nhs_stripe_rx
    import nhs_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lane_valid_i,
    output logic                      lane_ready_o,
    input  cw_t                       lane_bits_i,
    output logic                      out_valid_o,
    input  logic                      out_ready_i,
    output logic [DATA_W-1:0]         out_data_o,
    output logic [DATA_W/NIB_W-1:0]   out_fix_o
);

    localparam int NIBBLES = DATA_W / NIB_W;
    localparam int PH_W    = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NIBBLES - 1);

    typedef struct packed {
        logic [PH_W-1:0]    phase;
        logic [DATA_W-1:0]  acc;
        logic [NIBBLES-1:0] acc_fix;
        logic               oval;
        logic [DATA_W-1:0]  odata;
        logic [NIBBLES-1:0] ofix;
    } rx_state_t;

    rx_state_t st_d, st_q;
    nib_t      dec_nib;
    logic      dec_err;
    logic      take;

    nhs_ham_dec u_dec (
        .cw_i  (lane_bits_i),
        .nib_o (dec_nib),
        .err_o (dec_err)
    );

    always_comb begin
        st_d         = st_q;
        lane_ready_o = (st_q.phase != LAST_PH) || !st_q.oval || out_ready_i;
        take         = lane_valid_i && lane_ready_o;

        if (st_q.oval && out_ready_i) begin
            st_d.oval = 1'b0;
        end

        if (take) begin
            st_d.acc[st_q.phase*NIB_W +: NIB_W] = dec_nib;
            st_d.acc_fix[st_q.phase]            = dec_err;
            if (st_q.phase == LAST_PH) begin
                st_d.oval  = 1'b1;
                st_d.odata = st_d.acc;
                st_d.ofix  = st_d.acc_fix;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end

        out_valid_o = st_q.oval;
        out_data_o  = st_q.odata;
        out_fix_o   = st_q.ofix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_fix_o))) else $error("byte changed in stall"); // R9

    AST_BYTE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.phase == LAST_PH) |=> out_valid_o) else $error("no byte after last word"); // R8

endmodule

// File: rtl/nibble_stripe_codec.sv
module nibble_stripe_codec
    import nhs_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      tx_lane_valid,
    input  logic                      tx_lane_ready,
    output logic [CW_W-1:0]           tx_lane_bits,
    input  logic                      rx_lane_valid,
    output logic                      rx_lane_ready,
    input  logic [CW_W-1:0]           rx_lane_bits,
    output logic                      rd_valid,
    input  logic                      rd_ready,
    output logic [DATA_W-1:0]         rd_data,
    output logic [DATA_W/NIB_W-1:0]   rd_fix
);

    nhs_stripe_tx #(.DATA_W(DATA_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid_i   (wr_valid),
        .wr_ready_o   (wr_ready),
        .wr_data_i    (wr_data),
        .lane_valid_o (tx_lane_valid),
        .lane_ready_i (tx_lane_ready),
        .lane_bits_o  (tx_lane_bits)
    );

    nhs_stripe_rx #(.DATA_W(DATA_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_valid_i (rx_lane_valid),
        .lane_ready_o (rx_lane_ready),
        .lane_bits_i  (rx_lane_bits),
        .out_valid_o  (rd_valid),
        .out_ready_i  (rd_ready),
        .out_data_o   (rd_data),
        .out_fix_o    (rd_fix)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (!tx_lane_valid && !rd_valid)) else $error("not idle after reset"); // R1

endmodule

// File: tb/nibble_stripe_codec_tb.sv
module nibble_stripe_codec_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = 8'h00;
    logic       tx_lane_valid;
    logic       tx_lane_ready = 1'b1;
    logic [6:0] tx_lane_bits;
    logic       rx_lane_valid = 1'b0;
    logic       rx_lane_ready;
    logic [6:0] rx_lane_bits = 7'h00;
    logic       rd_valid;
    logic       rd_ready = 1'b1;
    logic [7:0] rd_data;
    logic [1:0] rd_fix;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    nibble_stripe_codec dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_data       (wr_data),
        .tx_lane_valid (tx_lane_valid),
        .tx_lane_ready (tx_lane_ready),
        .tx_lane_bits  (tx_lane_bits),
        .rx_lane_valid (rx_lane_valid),
        .rx_lane_ready (rx_lane_ready),
        .rx_lane_bits  (rx_lane_bits),
        .rd_valid      (rd_valid),
        .rd_ready      (rd_ready),
        .rd_data       (rd_data),
        .rd_fix        (rd_fix)
    );

    // {byte, lane to flip in low codeword (1..7, 0 none), same for high codeword}
    localparam logic [15:0] VEC [8] = '{
        {8'hA5, 4'd0, 4'd0},
        {8'h3C, 4'd1, 4'd7},
        {8'hFF, 4'd2, 4'd4},
        {8'h00, 4'd3, 4'd5},
        {8'h96, 4'd6, 4'd0},
        {8'h5A, 4'd0, 4'd3},
        {8'h71, 4'd4, 4'd2},
        {8'hE8, 4'd7, 4'd6}
    };

    function automatic logic [6:0] ref_cw(input logic [3:0] d);
        logic c1, c2, c4;
        c1 = d[0] ^ d[1] ^ d[3];
        c2 = d[0] ^ d[2] ^ d[3];
        c4 = d[1] ^ d[2] ^ d[3];
        return {d[3], d[2], d[1], c4, d[0], c2, c1};
    endfunction

    function automatic logic [6:0] flip_mask(input logic [3:0] pos);
        return (pos == 4'd0) ? 7'h00 : (7'h01 << (pos - 4'd1));
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic enc_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        chk("R1", "wr_ready idle", 32'(wr_ready), 32'd1);
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R3", "valid low word", 32'(tx_lane_valid), 32'd1);
        chk("R2", "low codeword", 32'(tx_lane_bits), 32'(ref_cw(b[3:0])));
        @(negedge clk);
        chk("R3", "high codeword", 32'(tx_lane_bits), 32'(ref_cw(b[7:4])));
        @(negedge clk);
        chk("R3", "idle after byte", 32'(tx_lane_valid), 32'd0);
    endtask

    task automatic dec_pair(input logic [6:0] lo, input logic [6:0] hi,
                            input logic [7:0] exp_b, input logic [1:0] exp_f);
        @(negedge clk);
        rx_lane_valid = 1'b1;
        rx_lane_bits  = lo;
        @(negedge clk);
        rx_lane_bits  = hi;
        @(negedge clk);
        rx_lane_valid = 1'b0;
        chk("R8", "rd_valid", 32'(rd_valid), 32'd1);
        chk("R6", "decoded byte", 32'(rd_data), 32'(exp_b));
        chk("R7", "fix flags", 32'(rd_fix), 32'(exp_f));
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog run did not end actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] b1, b2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "tx_lane_valid", 32'(tx_lane_valid), 32'd0);
        chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R1", "wr_ready", 32'(wr_ready), 32'd1);
        chk("R1", "rx_lane_ready", 32'(rx_lane_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: encode, then decode with injected lane faults
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            logic [3:0] fl, fh;
            b  = VEC[i][15:8];
            fl = VEC[i][7:4];
            fh = VEC[i][3:0];
            enc_byte(b);
            dec_pair(ref_cw(b[3:0]) ^ flip_mask(fl), ref_cw(b[7:4]) ^ flip_mask(fh),
                     b, {fh != 4'd0, fl != 4'd0});
        end

        // R4 back-to-back bytes
        b1 = 8'h4D; b2 = 8'hB2;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = b1;
        @(negedge clk);
        wr_data = b2;
        chk("R4", "busy blocks byte", 32'(wr_ready), 32'd0);
        chk("R4", "b1 low", 32'(tx_lane_bits), 32'(ref_cw(b1[3:0])));
        @(negedge clk);
        chk("R4", "ready on last word", 32'(wr_ready), 32'd1);
        chk("R4", "b1 high", 32'(tx_lane_bits), 32'(ref_cw(b1[7:4])));
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R4", "b2 low no gap", 32'(tx_lane_bits), 32'(ref_cw(b2[3:0])));
        chk("R4", "b2 valid", 32'(tx_lane_valid), 32'd1);
        @(negedge clk);
        chk("R4", "b2 high", 32'(tx_lane_bits), 32'(ref_cw(b2[7:4])));
        @(negedge clk);
        chk("R4", "idle", 32'(tx_lane_valid), 32'd0);

        // R5 encoder stall
        b1 = 8'hC3;
        tx_lane_ready = 1'b0;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = b1;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = 8'h11;
        for (int s = 0; s < 3; s++) begin
            chk("R5", "held low word", 32'(tx_lane_bits), 32'(ref_cw(b1[3:0])));
            chk("R5", "wr_ready in stall", 32'(wr_ready), 32'd0);
            @(negedge clk);
        end
        tx_lane_ready = 1'b1;
        @(negedge clk);
        chk("R5", "high after stall", 32'(tx_lane_bits), 32'(ref_cw(b1[7:4])));
        @(negedge clk);
        chk("R5", "idle after stall", 32'(tx_lane_valid), 32'd0);

        // R9 decoder stall with pop and load on the same edge
        b1 = 8'h69; b2 = 8'h2E;
        rd_ready = 1'b0;
        @(negedge clk);
        rx_lane_valid = 1'b1; rx_lane_bits = ref_cw(b1[3:0]);
        @(negedge clk);
        rx_lane_bits = ref_cw(b1[7:4]) ^ 7'h08;
        @(negedge clk);
        rx_lane_bits = ref_cw(b2[3:0]) ^ 7'h40;
        chk("R9", "first byte", 32'(rd_data), 32'(b1));
        @(negedge clk);
        rx_lane_bits = ref_cw(b2[7:4]);
        @(negedge clk);
        chk("R9", "second word refused", 32'(rx_lane_ready), 32'd0);
        chk("R9", "byte held", 32'(rd_data), 32'(b1));
        chk("R9", "flags held", 32'(rd_fix), 32'd2);
        rd_ready = 1'b1;
        @(negedge clk);
        rx_lane_valid = 1'b0;
        chk("R9", "new byte same edge", 32'(rd_data), 32'(b2));
        chk("R7", "new flags", 32'(rd_fix), 32'd1);
        chk("R8", "valid kept", 32'(rd_valid), 32'd1);
        @(negedge clk);
        chk("R8", "drained", 32'(rd_valid), 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule